// File: doc/BRIEF.md
# Interrupt Pin Timing Controller

This block drives an active-low interrupt request pin for a group of interrupt sources. Each source has a one-cycle event strobe and an enable bit. An enabled event that arrives while the chip is in an interrupt-capable operating mode sets a bit in a buffer register. The first such event pulls the pin low. The host reads the buffer through a decoded serial-bus read-only frame, and that read clears the buffer in the same cycle.

The pin sequencing sets a lower and an upper bound on how long the pin stays low. A read releases the pin only after `T_MIN` low cycles have passed. With no read, the pin releases after `T_TO` cycles and the buffer bits stay set. Every release is followed by a high gap of `T_TO` cycles. An event that lands inside the gap is remembered and produces a new pulse once the gap ends. That pulse is issued even if a read during the gap has already emptied the buffer.

The sequencer has three states. `ST_IDLE` is high with no gap running. `ST_LOW` is the pin asserted. `ST_GAP` is the forced high spacing. The transitions are:
- idle→low on an enabled event.
- low→gap on time-out, or on a read once the minimum width is met.
- gap→low at the end of the gap if an event is pending.
- gap→idle at the end of the gap if nothing is pending.
- any→idle when the mode leaves Normal/Stop.

Top module: `irq_pin_ctrl`

## Requirements
- R1: After reset the pin is high and the buffer reads zero. An enabled event in an active mode sets its buffer bit and drives the pin low on the next cycle.
- R2: A read is a strobe with command code 3'b111 and address 3'b000. During the strobe cycle `buf_o` shows the latched bits, and from the next cycle those bits are cleared. A strobe with any other command or address leaves the buffer unchanged.
- R3: Events from further sources while the pin is low merge into the same pulse. The buffer then shows every latched source.
- R4: With no read, the pin stays low for exactly `T_TO` cycles and then goes high. The buffer bits remain set.
- R5: Each release is followed by exactly `T_TO` high cycles before the pin can go low again. An enabled event during that gap makes the pin go low right after the gap.
- R6: A pin pulse lasts at least `T_MIN` cycles, even when the read comes in its first cycle. A read at low cycle k ≥ `T_MIN`-1 (counted from 0) releases the pin after k+1 low cycles.
- R7: A pulse reissued after a gap occurs even when the buffer was cleared during the gap, so the buffer can read as zero.
- R8: An event on a source whose enable bit is 0 neither sets a bit nor lowers the pin.
- R9: Mode encoding is 2'b00 Normal, 2'b01 Stop, 2'b10 Restart, 2'b11 Sleep. In Restart or Sleep the pin is high from the next cycle, events are not latched, and a pending reissue is dropped. Stop behaves like Normal.
- R10: An event in the same cycle as a read stays latched after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N_SRC | One-cycle event strobe per source |
| en_i | input | N_SRC | Enable bit per source |
| mode_i | input | 2 | Operating mode (00 Normal, 01 Stop, 10 Restart, 11 Sleep) |
| spi_stb_i | input | 1 | Decoded serial-bus frame strobe |
| spi_cmd_i | input | 3 | Frame command code |
| spi_addr_i | input | 3 | Frame register address |
| int_n_o | output | 1 | Active-low interrupt pin level |
| buf_o | output | N_SRC | Interrupt buffer contents (read data) |

## Verification
The bench targets these corner cases:
- **Read in the first low cycle.** A design that ignored the minimum width would release after one cycle.
- **Event inside the gap followed by a clearing read.** A design that tied the reissue to the buffer would stay silent.
- **Pulse reissued after the gap.** A design that skipped the gap would reassert too early.
- **Read and event in the same cycle.** A wrong clear priority loses the new bit.
- **Mode dropped out of Normal while a reissue is pending.** A design that kept the pending flag would emit a stray pulse.

Alongside these directed cases, a behavioural model compares the pin and the buffer on every cycle.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'b00,
        MODE_STOP    = 2'b01,
        MODE_RESTART = 2'b10,
        MODE_SLEEP   = 2'b11
    } op_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_LOW  = 2'b01,
        ST_GAP  = 2'b10
    } pin_state_e;

    localparam int CMD_W  = 3;
    localparam int ADDR_W = 3;
    localparam logic [CMD_W-1:0]  CMD_RD_ONLY = 3'b111;
    localparam logic [ADDR_W-1:0] ADDR_IRQ    = 3'b000;

endpackage

// File: rtl/irq_rd_decode.sv
module irq_rd_decode
    import irq_pin_pkg::*;
(
    input  logic              stb_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              rd_o
);
    always_comb begin
        rd_o = stb_i && (cmd_i == CMD_RD_ONLY) && (addr_i == ADDR_IRQ);
    end
endmodule

// File: rtl/irq_src_buffer.sv
module irq_src_buffer #(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_i,
    input  logic             clr_i,
    output logic [N_SRC-1:0] buf_o
);
    logic [N_SRC-1:0] bits_q;

    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    bits_q[g] <= 1'b0;
                else if (set_i[g])
                    bits_q[g] <= 1'b1;
                else if (clr_i)
                    bits_q[g] <= 1'b0;
            end
        end
    endgenerate

    assign buf_o = bits_q;

    // R2
    rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((bits_q & ~$past(set_i)) == '0));

    // R10
    set_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((bits_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_pin_seq.sv
module irq_pin_seq
    import irq_pin_pkg::*;
#(
    parameter int T_MIN = 4,
    parameter int T_TO  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic trig_i,
    input  logic rd_i,
    output logic int_n_o
);
    localparam int CW = $clog2(T_TO + 1);
    localparam logic [CW-1:0] MIN_LAST = CW'(T_MIN - 1);
    localparam logic [CW-1:0] TO_LAST  = CW'(T_TO - 1);
    localparam logic [CW-1:0] TO_SAT   = CW'(T_TO);

    pin_state_e st_q, st_nx;
    logic [CW-1:0] cnt_q;
    logic rd_q, pend_q;
    logic cnt_last, low_done;

    assign cnt_last = (cnt_q == TO_LAST);
    assign low_done = cnt_last || ((rd_q || rd_i) && (cnt_q >= MIN_LAST));

    always_comb begin
        st_nx = st_q;
        if (!active_i) begin
            st_nx = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: if (trig_i)   st_nx = ST_LOW;
                ST_LOW:  if (low_done) st_nx = ST_GAP;
                ST_GAP:  if (cnt_last) st_nx = (pend_q || trig_i) ? ST_LOW : ST_IDLE;
                default: st_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rd_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (st_nx != st_q)
                cnt_q <= '0;
            else if (st_q != ST_IDLE)
                cnt_q <= cnt_q + 1'b1;
            rd_q   <= (st_q == ST_LOW && st_nx == ST_LOW) ? (rd_q || rd_i) : 1'b0;
            pend_q <= (st_q == ST_GAP && st_nx == ST_GAP) ? (pend_q || trig_i) : 1'b0;
        end
    end

    always_comb begin
        int_n_o = (st_q != ST_LOW);
    end

    // Checker counters: consecutive low and high cycles of the pin.
    logic [CW-1:0] lo_len, hi_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_len <= '0;
            hi_len <= TO_SAT;
        end else begin
            lo_len <= int_n_o ? '0 : ((lo_len < TO_SAT) ? lo_len + 1'b1 : lo_len);
            if (!active_i || !int_n_o)
                hi_len <= !active_i ? TO_SAT : '0;
            else if (hi_len < TO_SAT)
                hi_len <= hi_len + 1'b1;
        end
    end

    // R4
    low_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n_o |-> (lo_len < TO_SAT));

    // R6
    min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(int_n_o) && $past(active_i)) |-> ($past(lo_len) >= MIN_LAST));

    // R5
    gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n_o) |-> (hi_len >= TO_SAT));

    // R9
    inactive_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> int_n_o);
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
    import irq_pin_pkg::*;
#(
    parameter int N_SRC = 4,
    parameter int T_MIN = 4,
    parameter int T_TO  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic [N_SRC-1:0] en_i,
    input  logic [1:0]       mode_i,
    input  logic             spi_stb_i,
    input  logic [2:0]       spi_cmd_i,
    input  logic [2:0]       spi_addr_i,
    output logic             int_n_o,
    output logic [N_SRC-1:0] buf_o
);
    logic             active, rd;
    logic [N_SRC-1:0] set;

    assign active = (mode_i == MODE_NORMAL) || (mode_i == MODE_STOP);
    assign set    = evt_i & en_i & {N_SRC{active}};

    irq_rd_decode u_dec (
        .stb_i  (spi_stb_i),
        .cmd_i  (spi_cmd_i),
        .addr_i (spi_addr_i),
        .rd_o   (rd)
    );

    irq_src_buffer #(.N_SRC(N_SRC)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set),
        .clr_i (rd),
        .buf_o (buf_o)
    );

    irq_pin_seq #(.T_MIN(T_MIN), .T_TO(T_TO)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .trig_i   (|set),
        .rd_i     (rd),
        .int_n_o  (int_n_o)
    );
endmodule

// File: tb/tb_irq_pin_ctrl.sv
module tb_irq_pin_ctrl;
    localparam int N  = 4;
    localparam int TM = 4;
    localparam int TT = 16;

    logic clk = 0;
    logic rst_n = 0;
    logic [N-1:0] evt = '0, en = '1;
    logic [1:0] mode = 2'b00;
    logic stb = 0;
    logic [2:0] cmd = '0, addr = '0;
    logic int_n;
    logic [N-1:0] buf_o;

    int checks = 0, errors = 0;

    irq_pin_ctrl #(.N_SRC(N), .T_MIN(TM), .T_TO(TT)) dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .en_i(en), .mode_i(mode),
        .spi_stb_i(stb), .spi_cmd_i(cmd), .spi_addr_i(addr),
        .int_n_o(int_n), .buf_o(buf_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural reference: phase 0 = idle, 1 = pin low, 2 = gap.
    int m_phase = 0, m_cnt = 0;
    bit m_rd = 0, m_pend = 0;
    logic [N-1:0] m_buf = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_rd = 0; m_pend = 0; m_buf = '0;
        end else begin
            bit act, rd, any, r, p;
            logic [N-1:0] ev;
            act = (mode == 2'b00) || (mode == 2'b01);
            ev  = act ? (evt & en) : '0;
            any = (ev != 0);
            rd  = stb && cmd == 3'b111 && addr == 3'b000;
            m_buf = (rd ? '0 : m_buf) | ev;
            if (!act) begin
                m_phase = 0; m_cnt = 0; m_rd = 0; m_pend = 0;
            end else if (m_phase == 0) begin
                if (any) begin m_phase = 1; m_cnt = 0; m_rd = 0; end
            end else if (m_phase == 1) begin
                r = m_rd | rd;
                if (m_cnt == TT - 1 || (r && m_cnt >= TM - 1)) begin
                    m_phase = 2; m_cnt = 0; m_pend = 0; m_rd = 0;
                end else begin
                    m_cnt++; m_rd = r;
                end
            end else begin
                p = m_pend | any;
                if (m_cnt == TT - 1) begin
                    m_phase = p ? 1 : 0; m_cnt = 0; m_pend = 0; m_rd = 0;
                end else begin
                    m_cnt++; m_pend = p;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(int_n === (m_phase != 1), "R1 R4 R5 R6 pin vs model", int'(int_n), int'(m_phase != 1));
            chk(buf_o === m_buf, "R2 R3 R10 buffer vs model", int'(buf_o), int'(m_buf));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fire(input logic [N-1:0] b);
        evt = b;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic rd_buf(input logic [2:0] c, input logic [2:0] a, output logic [N-1:0] got);
        stb = 1; cmd = c; addr = a;
        got = buf_o;
        @(negedge clk);
        stb = 0; cmd = '0; addr = '0;
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (int_n === 1'b0 && n < 100) begin n++; @(negedge clk); end
    endtask

    task automatic count_high(output int n);
        n = 0;
        while (int_n === 1'b1 && n < 100) begin n++; @(negedge clk); end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1: actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        logic [N-1:0] g;
        bit seen;
        cyc(2);
        chk(int_n === 1'b1, "R1 reset pin", int'(int_n), 1);
        chk(buf_o === '0, "R1 reset buffer", int'(buf_o), 0);
        rst_n = 1;
        cyc(2);

        // R1 and R4: single event, no read
        fire(4'b0001);
        chk(int_n === 1'b0, "R1 pin low after event", int'(int_n), 0);
        chk(buf_o === 4'b0001, "R1 bit latched", int'(buf_o), 1);
        count_low(n);
        chk(n == TT, "R4 time-out width", n, TT);
        chk(buf_o === 4'b0001, "R4 bit kept after time-out", int'(buf_o), 1);
        rd_buf(3'b111, 3'b000, g);
        chk(g === 4'b0001, "R2 read data", int'(g), 1);
        chk(buf_o === '0, "R2 cleared", int'(buf_o), 0);
        cyc(20);

        // R6: read in first low cycle
        fire(4'b0010);
        rd_buf(3'b111, 3'b000, g);
        count_low(n);
        chk(n + 1 == TM, "R6 minimum width", n + 1, TM);
        cyc(20);

        // R6: read at low cycle 7
        fire(4'b0010);
        cyc(7);
        rd_buf(3'b111, 3'b000, g);
        chk(int_n === 1'b1, "R6 release after late read", int'(int_n), 1);
        cyc(20);

        // R3: merged sources
        fire(4'b0001);
        cyc(2);
        fire(4'b0100);
        count_low(n);
        chk(n == TT - 3, "R3 single pulse", n, TT - 3);
        chk(buf_o === 4'b0101, "R3 both bits", int'(buf_o), 5);
        rd_buf(3'b111, 3'b000, g);
        cyc(20);

        // R5 and R7: event in gap, buffer cleared, pulse reissued
        fire(4'b0001);
        rd_buf(3'b111, 3'b000, g);
        count_low(n);
        fire(4'b0010);
        rd_buf(3'b111, 3'b000, g);
        chk(g === 4'b0010, "R5 gap event latched", int'(g), 2);
        count_high(n);
        chk(n == TT - 2, "R5 gap length", n, TT - 2);
        chk(int_n === 1'b0, "R7 reissued pulse", int'(int_n), 0);
        chk(buf_o === '0, "R7 empty buffer on reissue", int'(buf_o), 0);
        count_low(n);
        cyc(20);

        // R8: disabled source
        en = 4'b1110;
        fire(4'b0001);
        chk(int_n === 1'b1, "R8 no pulse", int'(int_n), 1);
        chk(buf_o === '0, "R8 not latched", int'(buf_o), 0);
        en = '1;

        // R9: inactive mode
        mode = 2'b10;
        fire(4'b0001);
        chk(int_n === 1'b1, "R9 restart no pulse", int'(int_n), 1);
        chk(buf_o === '0, "R9 restart not latched", int'(buf_o), 0);
        mode = 2'b00;
        cyc(2);
        fire(4'b0001);
        rd_buf(3'b111, 3'b000, g);
        count_low(n);
        fire(4'b0010);
        mode = 2'b11;
        cyc(1);
        mode = 2'b00;
        seen = 0;
        for (int i = 0; i < 25; i++) begin
            if (int_n === 1'b0) seen = 1;
            @(negedge clk);
        end
        chk(!seen, "R9 pending dropped", int'(seen), 0);
        rd_buf(3'b111, 3'b000, g);
        mode = 2'b01;
        fire(4'b0100);
        chk(int_n === 1'b0, "R9 stop mode active", int'(int_n), 0);
        count_low(n);
        cyc(20);
        mode = 2'b00;
        rd_buf(3'b111, 3'b000, g);
        cyc(2);

        // R2: wrong address / command
        fire(4'b1000);
        rd_buf(3'b111, 3'b001, g);
        chk(buf_o === 4'b1000, "R2 wrong address kept", int'(buf_o), 8);
        rd_buf(3'b110, 3'b000, g);
        chk(buf_o === 4'b1000, "R2 wrong command kept", int'(buf_o), 8);
        rd_buf(3'b111, 3'b000, g);
        chk(g === 4'b1000, "R2 read data", int'(g), 8);
        chk(buf_o === '0, "R2 cleared", int'(buf_o), 0);
        cyc(30);

        // R10: event coincident with read
        fire(4'b0001);
        evt = 4'b0010;
        rd_buf(3'b111, 3'b000, g);
        evt = '0;
        chk(g === 4'b0001, "R10 read data", int'(g), 1);
        chk(buf_o === 4'b0010, "R10 event kept", int'(buf_o), 2);
        cyc(40);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule